// File: doc/BRIEF.md
# Pointer Register Address Generator

This block holds the three 16-bit memory pointers X, Y and Z of an 8-bit processor core. Each pointer is made of two 8-bit halves that the register file writes one byte at a time. When the core issues an indirect memory operation, the block forms the effective address from the selected pointer and the addressing mode. It then computes the pointer's next value and, if write-back is enabled, stores it. The same datapath runs the word add-immediate and word subtract-immediate instructions on a pointer pair, and these produce their own set of five flags.

Operations are sequenced by a small state machine with four states. `ST_IDLE` accepts a request. `ST_ISSUE` presents the address. `ST_HOLD` is the extra cycle that only program-memory table reads take. `ST_FINISH` presents the result and commits it. The transitions are:
- IDLE→ISSUE when a legal request arrives.
- ISSUE→HOLD for table reads, and ISSUE→FINISH for everything else.
- HOLD→FINISH always.
- FINISH→IDLE always.

An illegal request does not leave IDLE and raises a one-cycle reject pulse instead.

Top module: `ptr_agen`

## Requirements
- R1: A byte write (`wr_en`, with `wr_sel` 0=X, 1=Y, 2=Z and `wr_hi` 1 selecting bits 15:8, 0 selecting bits 7:0) updates that half of the pointer in the next cycle. The write is applied only while `ready` is high, and it is ignored while an operation is in progress.
- R2: Operation codes are 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement, 4 table read, 5 table read with increment, 6 word add, 7 word subtract. Plain mode (code 0) addresses at the pointer value and leaves the pointer unchanged.
- R3: Post-increment (code 1) addresses at the pointer value, and the new pointer is that value plus one modulo 2^16.
- R4: Pre-decrement (code 2) addresses at the pointer value minus one modulo 2^16, and the new pointer is that same value.
- R5: Displacement (code 3) addresses at the pointer plus the unsigned 6-bit `k` modulo 2^16 and leaves the pointer unchanged. It is legal only for Y and Z.
- R6: A data operation (codes 0 to 3) raises `addr_valid` in the first cycle after it is accepted and `done` in the second.
- R7: Table reads (codes 4 and 5) are legal only on Z. They raise `addr_valid` and `addr_prog` one cycle after acceptance and raise `done` two cycles after that. Code 5 increments Z.
- R8: Word add (code 6) produces pointer + k. In the cycle after `done` the flags become valid, with bit 0 C (carry out of bit 15), bit 1 Z (zero), bit 2 N (bit 15 of the result), bit 3 V (the sign went from clear to set) and bit 4 S (N xor V). `done` rises two cycles after acceptance.
- R9: Word subtract (code 7) produces pointer − k. C is set when k exceeds the pointer, and V is set when the sign went from set to clear. Z, N and S follow the R8 rules.
- R10: With `wb_en` low, the pointer is left unchanged, while `ptr_new` still shows the computed value and the flags still update.
- R11: A request naming pointer 3, displacement on X, or a table read on X or Y is dropped. `reject` is high for exactly the next cycle and no state changes.
- R12: After reset all pointers and flags are zero and `ready` is high.
- R13: `start` is ignored while `ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Pointer byte write strobe |
| wr_sel | input | 2 | Pointer written: 0 X, 1 Y, 2 Z |
| wr_hi | input | 1 | 1 writes the upper byte, 0 the lower |
| wr_byte | input | 8 | Byte to write |
| start | input | 1 | Request strobe |
| op | input | 3 | Operation code (see R2) |
| sel | input | 2 | Pointer used by the request |
| k | input | 6 | Displacement or word immediate |
| wb_en | input | 1 | Store the updated pointer |
| ready | output | 1 | Idle, accepts a request |
| addr_valid | output | 1 | `eff_addr` valid this cycle |
| addr_prog | output | 1 | Address targets program memory |
| eff_addr | output | 16 | Effective address |
| done | output | 1 | Last cycle of an operation |
| ptr_new | output | 16 | Updated pointer value, valid with `done` |
| flags | output | 5 | {S,V,N,Z,C} from the last word operation |
| reject | output | 1 | Previous request was illegal |
| ptr_x | output | 16 | Current X |
| ptr_y | output | 16 | Current Y |
| ptr_z | output | 16 | Current Z |

## Verification
Results arrive at fixed offsets from the clock edge that accepts a request:
- The address comes one cycle after acceptance.
- `done` and `ptr_new` come two cycles after acceptance for data and word operations, and three cycles after for table reads.
- The stored pointer and the flags change one cycle after `done`.
- `reject` comes one cycle after the refused request.

The bench model steps on the same edges as the design, keeps the same per-operation cycle count, and compares every output one nanosecond after each rising edge. Each comparison therefore sees exactly the cycle in which its value is due. Address and result values are compared only in the cycles where `addr_valid` or `done` marks them valid.

// File: rtl/ptr_agen_pkg.sv
package ptr_agen_pkg;

    localparam int NUM_PTR = 3;
    localparam int SEL_W   = 2;

    localparam logic [SEL_W-1:0] SEL_X = 2'd0;
    localparam logic [SEL_W-1:0] SEL_Y = 2'd1;
    localparam logic [SEL_W-1:0] SEL_Z = 2'd2;

    typedef enum logic [2:0] {
        OP_IND  = 3'd0,
        OP_PINC = 3'd1,
        OP_PDEC = 3'd2,
        OP_DISP = 3'd3,
        OP_TBL  = 3'd4,
        OP_TBLI = 3'd5,
        OP_WADD = 3'd6,
        OP_WSUB = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_HOLD   = 2'd2,
        ST_FINISH = 2'd3
    } state_e;

    function automatic logic op_is_tbl(op_e o);
        return (o == OP_TBL) || (o == OP_TBLI);
    endfunction

    function automatic logic op_is_word(op_e o);
        return (o == OP_WADD) || (o == OP_WSUB);
    endfunction

    function automatic logic op_modifies(op_e o);
        return (o == OP_PINC) || (o == OP_PDEC) || (o == OP_TBLI) ||
               (o == OP_WADD) || (o == OP_WSUB);
    endfunction

    function automatic logic op_legal(op_e o, logic [SEL_W-1:0] s);
        logic ok;
        ok = (s != 2'd3);
        if ((o == OP_DISP) && (s == SEL_X)) ok = 1'b0;
        if (op_is_tbl(o) && (s != SEL_Z))   ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/ptr_agen_ctrl.sv
module ptr_agen_ctrl
    import ptr_agen_pkg::*;
#(
    parameter int OFS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  op_e              op_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [OFS_W-1:0] k_i,
    input  logic             wb_i,
    output op_e              cur_op,
    output logic [SEL_W-1:0] cur_sel,
    output logic [OFS_W-1:0] cur_k,
    output logic             cur_wb,
    output logic             ready,
    output logic             addr_valid,
    output logic             addr_prog,
    output logic             done,
    output logic             commit_we,
    output logic             reject
);

    state_e state, state_nxt;
    logic   take, refuse;

    assign take   = (state == ST_IDLE) && start && op_legal(op_i, sel_i);
    assign refuse = (state == ST_IDLE) && start && !op_legal(op_i, sel_i);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   state_nxt = take ? ST_ISSUE : ST_IDLE;
            ST_ISSUE:  state_nxt = op_is_tbl(cur_op) ? ST_HOLD : ST_FINISH;
            ST_HOLD:   state_nxt = ST_FINISH;
            ST_FINISH: state_nxt = ST_IDLE;
        endcase
    end

    // State register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_op  <= OP_IND;
            cur_sel <= SEL_X;
            cur_k   <= '0;
            cur_wb  <= 1'b0;
            reject  <= 1'b0;
        end else begin
            state  <= state_nxt;
            reject <= refuse;
            if (take) begin
                cur_op  <= op_i;
                cur_sel <= sel_i;
                cur_k   <= k_i;
                cur_wb  <= wb_i;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        ready      = 1'b0;
        addr_valid = 1'b0;
        addr_prog  = 1'b0;
        done       = 1'b0;
        commit_we  = 1'b0;
        unique case (state)
            ST_IDLE:   ready = 1'b1;
            ST_ISSUE: begin
                addr_valid = !op_is_word(cur_op);
                addr_prog  = op_is_tbl(cur_op);
            end
            ST_HOLD:   ;
            ST_FINISH: begin
                done      = 1'b1;
                commit_we = cur_wb && op_modifies(cur_op);
            end
        endcase
    end

    // R11
    reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> (state == ST_IDLE));

    // R6
    data_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE && !op_is_tbl(cur_op)) |=> (state == ST_FINISH));

    // R7
    tbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE && op_is_tbl(cur_op)) |=> (state == ST_HOLD));

    // R13
    busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE || state == ST_HOLD) |=> (state != ST_IDLE));

endmodule

// File: rtl/ptr_agen_alu.sv
module ptr_agen_alu
    import ptr_agen_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int OFS_W = 6
) (
    input  op_e              op_i,
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [OFS_W-1:0] k_i,
    output logic [PTR_W-1:0] addr_o,
    output logic [PTR_W-1:0] next_o,
    output logic [4:0]       flags_o
);

    localparam int EXT_W = PTR_W - OFS_W;

    logic [PTR_W-1:0] kext;
    logic [PTR_W:0]   sum, dif;
    logic [PTR_W-1:0] res;
    logic             c, v, n, z;

    assign kext = {{EXT_W{1'b0}}, k_i};
    assign sum  = {1'b0, ptr_i} + {1'b0, kext};
    assign dif  = {1'b0, ptr_i} - {1'b0, kext};

    always_comb begin
        addr_o = ptr_i;
        next_o = ptr_i;
        unique case (op_i)
            OP_IND, OP_TBL: ;
            OP_PINC, OP_TBLI: next_o = ptr_i + 1'b1;
            OP_PDEC: begin
                addr_o = ptr_i - 1'b1;
                next_o = ptr_i - 1'b1;
            end
            OP_DISP: addr_o = sum[PTR_W-1:0];
            OP_WADD: next_o = sum[PTR_W-1:0];
            OP_WSUB: next_o = dif[PTR_W-1:0];
        endcase
    end

    always_comb begin
        res = (op_i == OP_WSUB) ? dif[PTR_W-1:0] : sum[PTR_W-1:0];
        n   = res[PTR_W-1];
        z   = (res == '0);
        if (op_i == OP_WSUB) begin
            c = dif[PTR_W];
            v = ptr_i[PTR_W-1] & ~res[PTR_W-1];
        end else begin
            c = sum[PTR_W];
            v = ~ptr_i[PTR_W-1] & res[PTR_W-1];
        end
        flags_o = {n ^ v, v, n, z, c};
    end

endmodule

// File: rtl/ptr_agen_regs.sv
module ptr_agen_regs
    import ptr_agen_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         idle,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic                         wr_hi,
    input  logic [BYTE_W-1:0]            wr_byte,
    input  logic                         commit_we,
    input  logic [SEL_W-1:0]             commit_sel,
    input  logic [2*BYTE_W-1:0]          commit_val,
    input  logic                         flag_we,
    input  logic [4:0]                   flag_val,
    output logic [NUM_PTR*2*BYTE_W-1:0]  ptr_all,
    output logic [4:0]                   flags_q
);

    localparam int PTR_W = 2 * BYTE_W;

    logic byte_we;
    assign byte_we = idle && wr_en;

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        logic [BYTE_W-1:0] lo_q, hi_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (byte_we && wr_sel == SEL_W'(i)) begin
                if (wr_hi) hi_q <= wr_byte;
                else       lo_q <= wr_byte;
            end else if (commit_we && commit_sel == SEL_W'(i)) begin
                {hi_q, lo_q} <= commit_val;
            end
        end
        assign ptr_all[i*PTR_W +: PTR_W] = {hi_q, lo_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flags_q <= '0;
        else if (flag_we) flags_q <= flag_val;
    end

    // R1
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !commit_we) |=> $stable(ptr_all));

endmodule

// File: rtl/ptr_agen.sv
module ptr_agen
    import ptr_agen_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int OFS_W  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic                  wr_hi,
    input  logic [BYTE_W-1:0]     wr_byte,
    input  logic                  start,
    input  logic [2:0]            op,
    input  logic [1:0]            sel,
    input  logic [OFS_W-1:0]      k,
    input  logic                  wb_en,
    output logic                  ready,
    output logic                  addr_valid,
    output logic                  addr_prog,
    output logic [2*BYTE_W-1:0]   eff_addr,
    output logic                  done,
    output logic [2*BYTE_W-1:0]   ptr_new,
    output logic [4:0]            flags,
    output logic                  reject,
    output logic [2*BYTE_W-1:0]   ptr_x,
    output logic [2*BYTE_W-1:0]   ptr_y,
    output logic [2*BYTE_W-1:0]   ptr_z
);

    localparam int PTR_W = 2 * BYTE_W;

    op_e                       cur_op;
    logic [SEL_W-1:0]          cur_sel;
    logic [OFS_W-1:0]          cur_k;
    logic                      cur_wb;
    logic                      commit_we;
    logic [NUM_PTR*PTR_W-1:0]  ptr_all;
    logic [PTR_W-1:0]          cur_ptr;
    logic [4:0]                alu_flags;

    ptr_agen_ctrl #(.OFS_W(OFS_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_i       (op_e'(op)),
        .sel_i      (sel),
        .k_i        (k),
        .wb_i       (wb_en),
        .cur_op     (cur_op),
        .cur_sel    (cur_sel),
        .cur_k      (cur_k),
        .cur_wb     (cur_wb),
        .ready      (ready),
        .addr_valid (addr_valid),
        .addr_prog  (addr_prog),
        .done       (done),
        .commit_we  (commit_we),
        .reject     (reject)
    );

    always_comb begin
        unique case (cur_sel)
            SEL_Y:   cur_ptr = ptr_all[1*PTR_W +: PTR_W];
            SEL_Z:   cur_ptr = ptr_all[2*PTR_W +: PTR_W];
            default: cur_ptr = ptr_all[0 +: PTR_W];
        endcase
    end

    ptr_agen_alu #(.PTR_W(PTR_W), .OFS_W(OFS_W)) alu_i (
        .op_i    (cur_op),
        .ptr_i   (cur_ptr),
        .k_i     (cur_k),
        .addr_o  (eff_addr),
        .next_o  (ptr_new),
        .flags_o (alu_flags)
    );

    ptr_agen_regs #(.BYTE_W(BYTE_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (ready),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_hi      (wr_hi),
        .wr_byte    (wr_byte),
        .commit_we  (commit_we),
        .commit_sel (cur_sel),
        .commit_val (ptr_new),
        .flag_we    (done && op_is_word(cur_op)),
        .flag_val   (alu_flags),
        .ptr_all    (ptr_all),
        .flags_q    (flags)
    );

    assign ptr_x = ptr_all[0*PTR_W +: PTR_W];
    assign ptr_y = ptr_all[1*PTR_W +: PTR_W];
    assign ptr_z = ptr_all[2*PTR_W +: PTR_W];

    // R7
    prog_on_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_prog |-> (addr_valid && cur_sel == SEL_Z));

    // R4
    predec_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && cur_op == OP_PDEC) |=> (ptr_new == $past(eff_addr)));

endmodule

// File: tb/ptr_agen_tb_top.sv
`timescale 1ns/1ps
module ptr_agen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_hi = 1'b0, start = 1'b0, wb_en = 1'b0;
    logic [1:0]  wr_sel = '0, sel = '0;
    logic [7:0]  wr_byte = '0;
    logic [2:0]  op = '0;
    logic [5:0]  k = '0;
    logic        ready, addr_valid, addr_prog, done, reject;
    logic [15:0] eff_addr, ptr_new, ptr_x, ptr_y, ptr_z;
    logic [4:0]  flags;

    int nchk = 0, nerr = 0, ncyc = 0;

    always #2 clk = ~clk;

    ptr_agen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_hi(wr_hi),
        .wr_byte(wr_byte), .start(start), .op(op), .sel(sel), .k(k), .wb_en(wb_en),
        .ready(ready), .addr_valid(addr_valid), .addr_prog(addr_prog),
        .eff_addr(eff_addr), .done(done), .ptr_new(ptr_new), .flags(flags),
        .reject(reject), .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z)
    );

    // ---------------- reference model ----------------
    int  mp[3];
    int  mfl, cyc, len, mop, msel, mk;
    bit  act, mwb, mrej;

    function automatic int f_addr(int o, int p, int q);
        if (o == 2) return (p - 1) & 'hFFFF;
        if (o == 3) return (p + q) & 'hFFFF;
        return p;
    endfunction

    function automatic int f_next(int o, int p, int q);
        case (o)
            1, 5:    return (p + 1) & 'hFFFF;
            2:       return (p - 1) & 'hFFFF;
            6:       return (p + q) & 'hFFFF;
            7:       return (p - q) & 'hFFFF;
            default: return p;
        endcase
    endfunction

    function automatic int f_flags(int o, int p, int q);
        int r, c, v, n, z;
        r = f_next(o, p, q);
        if (o == 6) begin
            c = (p + q) > 65535;
            v = (p < 32768) && (r >= 32768);
        end else begin
            c = q > p;
            v = (p >= 32768) && (r < 32768);
        end
        n = r >= 32768;
        z = r == 0;
        return c | (z << 1) | (n << 2) | (v << 3) | ((n ^ v) << 4);
    endfunction

    function automatic bit f_legal(int o, int s);
        if (s == 3) return 0;
        if (o == 3 && s == 0) return 0;
        if ((o == 4 || o == 5) && s != 2) return 0;
        return 1;
    endfunction

    function automatic bit f_mod(int o);
        return o == 1 || o == 2 || o == 5 || o == 6 || o == 7;
    endfunction

    function automatic string f_tag(int o);
        case (o)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            6: return "R8";
            7: return "R9";
            default: return "R7";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mp = '{0, 0, 0};
            mfl = 0; act = 0; cyc = 0; len = 0; mrej = 0;
            mop = 0; msel = 0; mk = 0; mwb = 0;
        end else begin
            mrej = 0;
            if (act) begin
                if (cyc == len - 1) begin
                    if (mwb && f_mod(mop)) mp[msel] = f_next(mop, mp[msel], mk);
                    if (mop >= 6) mfl = f_flags(mop, mp[msel], mk);
                    if (mop >= 6 && mwb) mfl = f_flags(mop, (mop == 6) ? (mp[msel] - mk) & 'hFFFF
                                                               : (mp[msel] + mk) & 'hFFFF, mk);
                    act = 0;
                end else cyc++;
            end else begin
                if (wr_en && wr_sel != 3) begin
                    if (wr_hi) mp[wr_sel] = (mp[wr_sel] & 'h00FF) | (int'(wr_byte) << 8);
                    else       mp[wr_sel] = (mp[wr_sel] & 'hFF00) | int'(wr_byte);
                end
                if (start) begin
                    if (f_legal(op, sel)) begin
                        act = 1; cyc = 0;
                        mop = op; msel = sel; mk = k; mwb = wb_en;
                        len = (op == 4 || op == 5) ? 3 : 2;
                    end else mrej = 1;
                end
            end
        end
    end

    task automatic chk(string req, string what, int got, int exp);
        nchk++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    // compare every cycle, 1 ns after the rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            bit e_av, e_dn;
            e_av = act && cyc == 0 && mop < 6;
            e_dn = act && cyc == len - 1;
            chk("R13", "ready", ready, !act);
            chk((mop == 4 || mop == 5) ? "R7" : "R6", "addr_valid", addr_valid, e_av);
            chk("R7", "addr_prog", addr_prog, e_av && mop >= 4);
            if (e_av) chk(f_tag(mop), "eff_addr", eff_addr, f_addr(mop, mp[msel], mk));
            chk((mop == 4 || mop == 5) ? "R7" : "R6", "done", done, e_dn);
            if (e_dn) chk(mwb ? f_tag(mop) : "R10", "ptr_new", ptr_new, f_next(mop, mp[msel], mk));
            chk((mop == 7) ? "R9" : "R8", "flags", flags, mfl);
            chk("R11", "reject", reject, mrej);
            chk("R1", "ptr_x", ptr_x, mp[0]);
            chk("R1", "ptr_y", ptr_y, mp[1]);
            chk("R1", "ptr_z", ptr_z, mp[2]);
        end
    end

    // watchdog
    always @(posedge clk) begin
        ncyc++;
        if (ncyc > 150000) begin
            nerr++;
            $display("FAIL watchdog: actual %0d cycles expected completion", ncyc);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(int s, int hi, int b);
        @(negedge clk);
        wr_en = 1; wr_sel = 2'(s); wr_hi = 1'(hi); wr_byte = 8'(b);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic set_ptr(int s, int v);
        wr(s, 0, v & 'hFF);
        wr(s, 1, (v >> 8) & 'hFF);
    endtask

    task automatic do_op(int o, int s, int q, int w);
        @(negedge clk);
        start = 1; op = 3'(o); sel = 2'(s); k = 6'(q); wb_en = 1'(w);
        @(negedge clk);
        start = 0;
        while (!ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk("R12", "ready", ready, 1);
        chk("R12", "ptr_x", ptr_x, 0);
        chk("R12", "ptr_y", ptr_y, 0);
        chk("R12", "ptr_z", ptr_z, 0);
        chk("R12", "flags", flags, 0);

        set_ptr(0, 'h1234);          // R1
        set_ptr(1, 'hFFFF);
        set_ptr(2, 'h0000);
        do_op(0, 0, 0, 1);           // R2 plain
        do_op(1, 1, 0, 1);           // R3 wrap FFFF->0
        do_op(2, 2, 0, 1);           // R4 wrap 0->FFFF
        do_op(3, 1, 63, 1);          // R5 disp max
        do_op(3, 2, 5, 1);
        do_op(3, 0, 5, 1);           // R11 disp on X
        do_op(4, 1, 0, 1);           // R11 table on Y
        do_op(0, 3, 0, 1);           // R11 pointer 3
        do_op(5, 2, 0, 1);           // R7 table inc
        do_op(4, 2, 0, 1);           // R7 table
        do_op(6, 0, 5, 1);           // R8
        set_ptr(0, 'h7FFF);
        do_op(6, 0, 1, 1);           // R8 V,N,S
        set_ptr(1, 'hFFF0);
        do_op(6, 1, 16, 1);          // R8 C,Z
        set_ptr(2, 'h0000);
        do_op(7, 2, 1, 1);           // R9 borrow
        set_ptr(0, 'h8000);
        do_op(7, 0, 1, 1);           // R9 V
        do_op(1, 0, 0, 0);           // R10 no write-back
        do_op(7, 1, 3, 0);           // R10 flags still update

        // R13: start held through a busy op, R1 byte write while busy
        @(negedge clk);
        start = 1; op = 3'd1; sel = 2'd1; k = 0; wb_en = 1;
        @(negedge clk);
        op = 3'd6; sel = 2'd0; k = 6'd9;
        wr_en = 1; wr_sel = 2'd2; wr_hi = 0; wr_byte = 8'hA5;
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);
        start = 0;
        while (!ready) @(negedge clk);

        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 3) == 0)
                wr($urandom_range(0, 2), $urandom_range(0, 1), $urandom_range(0, 255));
            do_op($urandom_range(0, 7), $urandom_range(0, 3),
                  $urandom_range(0, 63), $urandom_range(0, 3) != 0);
        end

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule